// File: doc/BRIEF.md
# Bitplane Pixel Serializer

This block turns a frame held as four separate 1-bit planes into a stream of 4-bit color indices for a raster display pipeline. Each plane has its own 32-bit shift register. On every pixel slot inside active video, the block takes bit 0 of all four registers, combines them into one color index, and shifts all four registers right together. The pixels of a word therefore come out least significant bit first.

Every 32 pixels the four registers reload at the same time from a prefetch buffer of four plane words. As soon as a reload consumes the buffer, the block asks memory for the four words of the next pixel-word index. It reads them one plane per transaction, in the order plane 0, 1, 2, 3. Word n of plane p is at byte address `BASE_ADDR + p*PLANE_BYTES + 4*n`. The default base is 0E7F00h.

A frame-start pulse, given during blanking, resets the word index to 0 and preloads the buffer. The first active pixel then comes straight from memory data with no warm-up. If the buffer is still incomplete when a reload is due, the block raises an underrun pulse and outputs zeros for that whole word. It also skips that word's index, so later words stay aligned with the raster.

The request port uses a valid/ready handshake. While `req_valid` is high and `req_ready` is low, the address is held stable. The block keeps at most one request outstanding. The response channel has no back-pressure: `rsp_valid` may arrive in any cycle and is always accepted. Responses return in request order.

Top module: `bitplane_serializer`

## Requirements
- R1: After reset, `pix_out` is 0, `underrun` is 0 and `req_valid` is 0.
- R2: After a `frame_start` pulse, the block issues the four reads for word index 0 in plane order 0,1,2,3 at addresses `BASE_ADDR + p*PLANE_BYTES` (0E7F00h, 0F1500h, 0FAB00h, 104100h with the defaults).
- R3: Once `req_valid` is high, it stays high with an unchanged `req_addr` until `req_ready` is sampled high. No new request is accepted while a response is still due.
- R4: Bit p of `pix_out` (bit 0 = plane 0) is bit k of the current plane-p word, where k = 0..31 counts the active pixels of that word. Word n+1 follows word n without a gap.
- R5: `pix_out` is registered. It updates only at a clock edge where `pix_en` is high, and it holds its value in every other cycle.
- R6: A `pix_en` cycle with `active` low drives `pix_out` to 0 and does not advance the shift registers. Pixels resume from the same bit afterwards.
- R7: The reload that starts word n issues the reads for word n+1, beginning at address `BASE_ADDR + 4*(n+1)`.
- R8: When a reload is due and the buffer is incomplete, `underrun` is high for exactly the one output cycle of that pixel. The 32 pixels of that word are 0, any read still in flight for it is discarded, and the next word shown is index n+1.
- R9: A `frame_start` pulse given in the middle of a word or a fetch drops the partial word and any in-flight data. The next active pixels are word 0 from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse in blanking: restart at word 0 and preload |
| pix_en | input | 1 | Pixel-slot enable |
| active | input | 1 | High inside active video, sampled with `pix_en` |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address of the requested plane word |
| rsp_valid | input | 1 | Read data valid (no back-pressure) |
| rsp_data | input | WORD_W | Read data |
| pix_out | output | 4 | Color index, bit p from plane p |
| underrun | output | 1 | One-cycle pulse when a word was not ready in time |

## Verification
The main pixel path is tried in three ways:
- A full-rate pixel enable, with blanking slots placed in the middle of a word. This separates a correct bit counter from one that advances during blanking.
- A one-in-three pixel enable while memory toggles `req_ready` every cycle. This shows that held requests and slow fetches still deliver words in order.
- A memory that refuses the first request, which forces an underrun. This separates skipping the missed index from showing the late data one word behind.

A frame restart issued mid-word and mid-fetch checks that stale responses never reach the screen. The address log covers the per-plane offsets and the index steps.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
  localparam int unsigned NPLANES = 4;
  typedef logic [NPLANES-1:0] pix_t;
  typedef logic [$clog2(NPLANES)-1:0] plane_t;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fstate_e;
endpackage

// File: rtl/bp_fetch.sv
`timescale 1ns/1ps
// Prefetch buffer and sequential per-plane read engine.
module bp_fetch
  import bp_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned IDX_W       = 12,
  parameter int unsigned BASE_ADDR   = 'hE7F00,
  parameter int unsigned PLANE_BYTES = 'h9600
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_start,
  input  logic                             take,
  input  logic                             miss,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [ADDR_W-1:0]                req_addr,
  input  logic                             rsp_valid,
  input  logic [WORD_W-1:0]                rsp_data,
  output logic [NPLANES-1:0][WORD_W-1:0]   words,
  output logic                             full
);
  localparam plane_t LAST_PLANE = plane_t'(NPLANES - 1);

  fstate_e          st;
  plane_t           plane;
  logic [IDX_W-1:0] idx, nidx;
  logic             restart;
  logic             kick, redo;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [IDX_W-1:0] i, input plane_t p);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(BASE_ADDR) + ADDR_W'(PLANE_BYTES) * ADDR_W'(p) + ADDR_W'({i, 2'b00});
    return a;
  endfunction

  assign kick      = frame_start | take | miss;
  assign redo      = frame_start | miss;
  assign req_valid = (st == F_REQ);

  always_comb begin
    if (frame_start)       nidx = '0;
    else if (take || miss) nidx = idx + 1'b1;
    else                   nidx = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      plane    <= '0;
      idx      <= '0;
      restart  <= 1'b0;
      full     <= 1'b0;
      req_addr <= '0;
      words    <= '0;
    end else begin
      idx <= nidx;
      if (frame_start || take) full <= 1'b0;
      unique case (st)
        F_IDLE: begin
          if (kick) begin
            st       <= F_REQ;
            plane    <= '0;
            req_addr <= addr_of(nidx, '0);
          end
        end
        F_REQ: begin
          if (req_ready) st <= F_WAIT;
          if (redo) restart <= 1'b1;
        end
        F_WAIT: begin
          if (rsp_valid) begin
            if (restart || redo) begin
              // stale data: throw away and refetch from plane 0
              restart  <= 1'b0;
              st       <= F_REQ;
              plane    <= '0;
              req_addr <= addr_of(nidx, '0);
            end else begin
              words[plane] <= rsp_data;
              if (plane == LAST_PLANE) begin
                st   <= F_IDLE;
                full <= 1'b1;
              end else begin
                plane    <= plane + 1'b1;
                st       <= F_REQ;
                req_addr <= addr_of(idx, plane + 1'b1);
              end
            end
          end else if (redo) begin
            restart <= 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bp_shift.sv
`timescale 1ns/1ps
// Four lockstep plane shifters and the pixel output register.
module bp_shift
  import bp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_start,
  input  logic                           pix_en,
  input  logic                           active,
  input  logic [NPLANES-1:0][WORD_W-1:0] words,
  input  logic                           full,
  output logic                           take,
  output logic                           miss,
  output pix_t                           pix_out,
  output logic                           underrun
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0] cnt;
  logic             empty, step;
  pix_t             cur;

  assign empty = (cnt == '0);
  assign step  = pix_en & active;
  assign take  = step & empty & full & ~frame_start;
  assign miss  = step & empty & ~full & ~frame_start;

  for (genvar p = 0; p < NPLANES; p++) begin : g_lane
    logic [WORD_W-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh <= '0;
      end else if (step) begin
        if (empty) sh <= full ? (words[p] >> 1) : '0;
        else       sh <= sh >> 1;
      end
    end
    // when empty, bit 0 comes straight from the buffer word being loaded
    assign cur[p] = empty ? (full & words[p][0]) : sh[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pix_out  <= '0;
      underrun <= 1'b0;
    end else begin
      if (frame_start)  cnt <= '0;
      else if (step)    cnt <= empty ? CNT_W'(WORD_W - 1) : cnt - 1'b1;
      underrun <= miss;
      if (pix_en) pix_out <= active ? cur : '0;
    end
  end
endmodule

// File: rtl/bitplane_serializer.sv
`timescale 1ns/1ps
module bitplane_serializer
  import bp_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned IDX_W       = 12,
  parameter int unsigned BASE_ADDR   = 'hE7F00,
  parameter int unsigned PLANE_BYTES = 'h9600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_en,
  input  logic              active,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic [3:0]        pix_out,
  output logic              underrun
);
  logic [NPLANES-1:0][WORD_W-1:0] words;
  logic full, take, miss;

  bp_fetch #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASE_ADDR(BASE_ADDR), .PLANE_BYTES(PLANE_BYTES)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .take(take), .miss(miss),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .words(words), .full(full)
  );

  bp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_en(pix_en), .active(active),
    .words(words), .full(full),
    .take(take), .miss(miss),
    .pix_out(pix_out), .underrun(underrun)
  );
endmodule

// File: rtl/bp_serializer_chk.sv
`timescale 1ns/1ps
module bp_serializer_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              active,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [3:0]        pix_out,
  input logic              underrun
);
  logic [1:0] outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + {1'b0, (req_valid && req_ready)} - {1'b0, rsp_valid};
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R3
  single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outst != 2'd0) |-> !(req_valid && req_ready));

  // R5
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_out));

  // R6
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !active) |=> (pix_out == 4'd0));

  // R8
  under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (pix_out == 4'd0));

  // R8
  under_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
endmodule

bind bitplane_serializer bp_serializer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .active(active),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .pix_out(pix_out), .underrun(underrun)
);

// File: tb/tb_bitplane_serializer.sv
`timescale 1ns/1ps
module tb_bitplane_serializer;
  localparam int unsigned WW = 32;
  localparam int unsigned AW = 24;
  localparam int unsigned IW = 12;
  localparam logic [23:0] BASE = 24'hE7F00;
  localparam logic [23:0] PB   = 24'h9600;

  typedef struct { logic [4:0] v; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, pix_en = 1'b0, active = 1'b0;
  logic req_valid, req_ready, rsp_valid = 1'b0;
  logic [AW-1:0] req_addr;
  logic [WW-1:0] rsp_data = '0;
  logic [3:0] pix_out;
  logic underrun;

  bitplane_serializer #(
    .WORD_W(WW), .ADDR_W(AW), .IDX_W(IW), .BASE_ADDR('hE7F00), .PLANE_BYTES('h9600)
  ) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_en(pix_en), .active(active),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pix_out(pix_out), .underrun(underrun)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t expq[$];
  logic [23:0] alog[$];
  int exp_idx = 0, exp_bit = 0;
  logic [3:0] last_e = '0;
  bit en_s = 0;
  bit stall_r = 0, force_stall = 0, jitter = 0;
  bit mbusy = 0;
  int mcnt = 0;
  logic [23:0] maddr = '0;
  localparam int LAT = 2;

  function automatic logic [31:0] memf(input logic [23:0] a);
    logic [31:0] x;
    x = {8'h00, a};
    return (x * 32'h9E3779B1) ^ (x << 11) ^ 32'hC3A50F1E;
  endfunction

  function automatic logic [3:0] ep(input int idx, input int b);
    logic [3:0] e;
    logic [31:0] w;
    for (int p = 0; p < 4; p++) begin
      w = memf(BASE + PB * 24'(p) + 24'(4 * idx));
      e[p] = w[b];
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model
  assign req_ready = !stall_r;
  always @(posedge clk) begin
    stall_r   <= jitter ? ~stall_r : force_stall;
    rsp_valid <= 1'b0;
    if (mbusy) begin
      if (mcnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= memf(maddr);
        mbusy     <= 0;
      end else mcnt <= mcnt - 1;
    end
    if (rst_n && req_valid && req_ready) begin
      mbusy <= 1;
      mcnt  <= LAT;
      maddr <= req_addr;
      alog.push_back(req_addr);
    end
  end

  // monitor
  always @(posedge clk) en_s <= pix_en;
  always @(negedge clk) begin
    if (rst_n && en_s) begin
      if (expq.size() == 0) chk(0, "R4", "unexpected pixel", int'(pix_out), 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk({underrun, pix_out} == e.v, e.tag, "pixel {underrun,pix}", int'({underrun, pix_out}), int'(e.v));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      pix_en = 0; active = 0;
    end
  endtask

  task automatic px(input bit act, input int gap, input string tag);
    exp_t e;
    e.v = 5'd0; e.tag = tag;
    if (act) begin
      e.v = {1'b0, ep(exp_idx, exp_bit)};
      exp_bit++;
      if (exp_bit == 32) begin exp_bit = 0; exp_idx++; end
    end
    last_e = e.v[3:0];
    @(posedge clk); #1;
    pix_en = 1; active = act;
    expq.push_back(e);
    for (int i = 1; i < gap; i++) begin
      @(posedge clk); #1;
      pix_en = 0;
    end
  endtask

  task automatic pxz(input bit ue);
    exp_t e;
    e.v = {ue, 4'd0}; e.tag = "R8";
    @(posedge clk); #1;
    pix_en = 1; active = 1;
    expq.push_back(e);
  endtask

  task automatic fs();
    @(posedge clk); #1;
    pix_en = 0; active = 0; frame_start = 1;
    @(posedge clk); #1;
    frame_start = 0;
    exp_idx = 0; exp_bit = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(pix_out == 0, "R1", "pix_out after reset", int'(pix_out), 0);
    chk(underrun == 0, "R1", "underrun after reset", int'(underrun), 0);
    chk(req_valid == 0, "R1", "req_valid after reset", int'(req_valid), 0);

    // preload of word 0
    fs();
    idle(40);
    chk(alog.size() >= 4, "R2", "request count", alog.size(), 4);
    for (int p = 0; p < 4; p++)
      if (alog.size() > p) chk(alog[p] == BASE + PB * 24'(p), "R2", "plane address", int'(alog[p]), int'(BASE + PB * 24'(p)));

    // full rate, blanking inside a word
    for (int i = 0; i < 16; i++) px(1, 1, "R4");
    for (int i = 0; i < 8; i++)  px(0, 1, "R6");
    for (int i = 0; i < 48; i++) px(1, 1, "R6");
    idle(5);
    @(negedge clk);
    chk(pix_out == last_e, "R5", "hold without pix_en", int'(pix_out), int'(last_e));
    if (alog.size() > 4) chk(alog[4] == BASE + 24'd4, "R7", "next word address", int'(alog[4]), int'(BASE + 24'd4));
    else chk(0, "R7", "next word missing", alog.size(), 5);
    for (int i = 0; i < 64; i++) px(1, 1, "R7");

    // slow pixel rate with request back-pressure
    jitter = 1;
    for (int i = 0; i < 64; i++) px(1, 3, "R3");
    jitter = 0;
    idle(3);

    // restart mid-word and mid-fetch
    for (int i = 0; i < 5; i++) px(1, 1, "R9");
    fs();
    idle(40);
    for (int i = 0; i < 32; i++) px(1, 1, "R9");
    idle(40);

    // underrun: memory refuses the first request
    force_stall = 1;
    fs();
    idle(5);
    for (int i = 0; i < 32; i++) pxz(i == 0);
    exp_idx = 1; exp_bit = 0;
    idle(1);
    begin
      int m;
      m = alog.size();
      force_stall = 0;
      idle(60);
      chk(alog.size() >= m + 2, "R8", "refetch count", alog.size(), m + 2);
      if (alog.size() >= m + 2) begin
        chk(alog[m] == BASE, "R8", "late request", int'(alog[m]), int'(BASE));
        chk(alog[m+1] == BASE + 24'd4, "R8", "skipped index", int'(alog[m+1]), int'(BASE + 24'd4));
      end
    end
    for (int i = 0; i < 64; i++) px(1, 1, "R8");
    idle(5);
    chk(expq.size() == 0, "R4", "pending expectations", expq.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule